// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block is a small register, four bits wide by default, that a two-bit mode select switches between four actions: keep its contents, shift toward one end, shift toward the other end, or take a whole word from its parallel inputs. Each direction of shift has its own serial input, and that input enters the register at a fixed end bit. A selector in front of every flip-flop picks the next value of that bit. A synchronous clear empties the register.

The bits are named by position. The A end is `q[WIDTH-1]` and the D end is `q[0]`. A right shift moves data from the A end toward the D end. A left shift moves data from the D end toward the A end.

Several instances can be chained through their serial pins. Two chained pairs, joined by one serial line, carry an eight-bit word from a parallel-loaded sender to a receiver that is read in parallel. This is the usual use of the block for parallel-to-serial and serial-to-parallel conversion.

Top module: `quad_mode_shifter`

## Requirements
- R1: When `clr` is high at a rising edge, `q` becomes all zeros at that edge, whatever `mode` is. This includes mode 11. From reset, `q` reads zero.
- R2: With `mode` = 00 and `clr` low, `q` keeps its value across the edge.
- R3: With `mode` = 01 (shift right), `ser_right_in` becomes the new `q[WIDTH-1]` (the A end), and every other bit `q[i]` takes the old `q[i+1]`.
- R4: With `mode` = 10 (shift left), `ser_left_in` becomes the new `q[0]` (the D end), and every other bit `q[i]` takes the old `q[i-1]`.
- R5: With `mode` = 11 (load), `q` takes `par_in` at the edge. `par_in[WIDTH-1]` goes to the A end.
- R6: Inputs that the selected mode does not use have no effect on `q`. This covers `ser_left_in` during a right shift, `ser_right_in` during a left shift, and `par_in` in any mode other than 11.
- R7: Two 4-bit senders and two 4-bit receivers are chained through their right-shift serial pins. The D end of each register feeds the next one, and a single line joins the sender pair to the receiver pair. After one load of an 8-bit word and exactly eight right-shift clocks, the receiver pair's parallel outputs, upper register first, equal the word. After seven shift clocks they do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| clr | input | 1 | Synchronous active-high clear; overrides every mode |
| mode | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 parallel load |
| par_in | input | WIDTH | Parallel data; bit WIDTH-1 is the A end |
| ser_left_in | input | 1 | Serial data entering at the D end on a left shift |
| ser_right_in | input | 1 | Serial data entering at the A end on a right shift |
| q | output | WIDTH | Register contents; bit WIDTH-1 is the A end, bit 0 the D end |

## Verification
The bench drives each serial input with a value opposite to the serial input in use. A design that swapped the two serial pins, or fed them in at the wrong end, would then show a wrong bit at once. It holds the clear high while mode 11 is applied with a non-zero word. A design that gave the load priority over the clear would show that word. It changes `par_in` during hold and shift steps, so a selector that leaked the parallel data into those modes would be caught. The cascade test compares the receiver word after seven and after eight shift clocks. An off-by-one in the shift direction, or in the bit order along the chain, shows up as a mismatch in one of those two reads.

// File: rtl/quad_shift_pkg.sv
package quad_shift_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } shift_mode_e;

    // One-hot action select; all zero means hold.
    typedef struct packed {
        logic shr;
        logic shl;
        logic load;
    } mode_sel_t;

    function automatic mode_sel_t decode_mode(input shift_mode_e m);
        mode_sel_t s;
        s = '0;
        unique case (m)
            MODE_SHR:  s.shr  = 1'b1;
            MODE_SHL:  s.shl  = 1'b1;
            MODE_LOAD: s.load = 1'b1;
            default:   s      = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/qms_mode_decode.sv
module qms_mode_decode
    import quad_shift_pkg::*;
(
    input  logic [1:0] mode_i,
    output mode_sel_t  sel_o
);

    always_comb begin
        sel_o = decode_mode(shift_mode_e'(mode_i));
    end

endmodule

// File: rtl/qms_bit_cell.sv
module qms_bit_cell
    import quad_shift_pkg::*;
(
    input  logic      clk,
    input  logic      clr,
    input  mode_sel_t sel,
    input  logic      from_a_side,
    input  logic      from_d_side,
    input  logic      par_bit,
    output logic      q_bit
);

    logic nxt;

    always_comb begin
        if (sel.load)
            nxt = par_bit;
        else if (sel.shr)
            nxt = from_a_side;
        else if (sel.shl)
            nxt = from_d_side;
        else
            nxt = q_bit;
    end

    always_ff @(posedge clk) begin
        if (clr)
            q_bit <= 1'b0;
        else
            q_bit <= nxt;
    end

endmodule

// File: rtl/quad_mode_shifter.sv
module quad_mode_shifter
    import quad_shift_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_left_in,
    input  logic             ser_right_in,
    output logic [WIDTH-1:0] q
);

    localparam int A_END = WIDTH - 1;
    localparam int D_END = 0;

    mode_sel_t sel;

    qms_mode_decode u_decode (
        .mode_i (mode),
        .sel_o  (sel)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic a_src;
        logic d_src;

        if (i == A_END) begin : g_a_end
            assign a_src = ser_right_in;
        end else begin : g_a_mid
            assign a_src = q[i+1];
        end

        if (i == D_END) begin : g_d_end
            assign d_src = ser_left_in;
        end else begin : g_d_mid
            assign d_src = q[i-1];
        end

        qms_bit_cell u_cell (
            .clk         (clk),
            .clr         (clr),
            .sel         (sel),
            .from_a_side (a_src),
            .from_d_side (d_src),
            .par_bit     (par_in[i]),
            .q_bit       (q[i])
        );
    end

endmodule

// File: rtl/qms_checker.sv
module qms_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr,
    input logic [1:0]       mode,
    input logic [WIDTH-1:0] par_in,
    input logic             ser_left_in,
    input logic             ser_right_in,
    input logic [WIDTH-1:0] q
);

    logic seen_edge = 1'b0;

    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!seen_edge)
        clr |=> (q == '0)); // R1

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (clr)
        (mode == 2'b00) |=> $stable(q)); // R2

    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (clr)
        (mode == 2'b01) |=> (q == {$past(ser_right_in), $past(q[WIDTH-1:1])})); // R3

    AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (clr)
        (mode == 2'b10) |=> (q == {$past(q[WIDTH-2:0]), $past(ser_left_in)})); // R4

    AST_LOAD_WORD: assert property (@(posedge clk) disable iff (clr)
        (mode == 2'b11) |=> (q == $past(par_in))); // R5

endmodule

bind quad_mode_shifter qms_checker #(.WIDTH(WIDTH)) u_qms_checker (
    .clk          (clk),
    .clr          (clr),
    .mode         (mode),
    .par_in       (par_in),
    .ser_left_in  (ser_left_in),
    .ser_right_in (ser_right_in),
    .q            (q)
);

// File: tb/test_quad_mode_shifter.sv
module test_quad_mode_shifter;

    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr;
    logic [1:0]   mode;
    logic [W-1:0] par_in;
    logic         sl;
    logic         sr;
    logic [W-1:0] q;

    int checks = 0;
    int errors = 0;

    // Behavioural model: index 0 is the A end, last index the D end.
    bit model[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_mode_shifter #(.WIDTH(W)) i_quad_mode_shifter (
        .clk (clk), .clr (clr), .mode (mode), .par_in (par_in),
        .ser_left_in (sl), .ser_right_in (sr), .q (q)
    );

    // Cascade: two senders, one serial line, two receivers
    logic       c_clr;
    logic [1:0] c_mode;
    logic [7:0] c_word;
    logic [3:0] tx_hi_q, tx_lo_q, rx_hi_q, rx_lo_q;

    quad_mode_shifter #(.WIDTH(4)) u_tx_hi (
        .clk (clk), .clr (c_clr), .mode (c_mode), .par_in (c_word[7:4]),
        .ser_left_in (1'b0), .ser_right_in (1'b0), .q (tx_hi_q)
    );
    quad_mode_shifter #(.WIDTH(4)) u_tx_lo (
        .clk (clk), .clr (c_clr), .mode (c_mode), .par_in (c_word[3:0]),
        .ser_left_in (1'b0), .ser_right_in (tx_hi_q[0]), .q (tx_lo_q)
    );
    quad_mode_shifter #(.WIDTH(4)) u_rx_hi (
        .clk (clk), .clr (c_clr), .mode (c_mode), .par_in (4'h0),
        .ser_left_in (1'b0), .ser_right_in (tx_lo_q[0]), .q (rx_hi_q)
    );
    quad_mode_shifter #(.WIDTH(4)) u_rx_lo (
        .clk (clk), .clr (c_clr), .mode (c_mode), .par_in (4'h0),
        .ser_left_in (1'b0), .ser_right_in (rx_hi_q[0]), .q (rx_lo_q)
    );

    function automatic logic [W-1:0] model_vec();
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) v[W-1-i] = model[i];
        return v;
    endfunction

    task automatic check_val(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; applies inputs, steps one edge, compares.
    task automatic step(input logic c, input logic [1:0] m, input logic [W-1:0] p,
                        input logic l, input logic r, input string tag);
        clr = c; mode = m; par_in = p; sl = l; sr = r;
        @(posedge clk);
        if (c) begin
            foreach (model[i]) model[i] = 0;
        end else begin
            case (m)
                2'b01: begin model.push_front(r); void'(model.pop_back()); end
                2'b10: begin void'(model.pop_front()); model.push_back(l); end
                2'b11: for (int i = 0; i < W; i++) model[i] = p[W-1-i];
                default: ;
            endcase
        end
        #(CLK_PERIOD/4);
        check_val({4'h0, q}, {4'h0, model_vec()}, tag);
        @(negedge clk);
    endtask

    task automatic cstep(input logic c, input logic [1:0] m);
        c_clr = c; c_mode = m;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cascade(input logic [7:0] word);
        c_word = word;
        cstep(1'b1, 2'b00);
        cstep(1'b0, 2'b11);
        c_word = 8'h00;
        for (int k = 0; k < 7; k++) cstep(1'b0, 2'b01);
        // R7: one clock short the word is not yet complete
        check_val({rx_hi_q, rx_lo_q}, {word[6:0], 1'b0}, "R7 after seven shifts");
        cstep(1'b0, 2'b01);
        check_val({rx_hi_q, rx_lo_q}, word, "R7 after eight shifts");
        cstep(1'b0, 2'b00);
        check_val({rx_hi_q, rx_lo_q}, word, "R7 receiver holds word");
        check_val({tx_hi_q, tx_lo_q}, 8'h00, "R7 sender emptied");
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        errors++;
        $display("FAIL watchdog expired (R1 to R7 not completed)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < W; i++) model.push_back(0);
        clr = 1'b1; mode = 2'b00; par_in = '0; sl = 1'b0; sr = 1'b0;
        c_clr = 1'b1; c_mode = 2'b00; c_word = 8'h00;
        @(negedge clk);
        step(1'b1, 2'b00, 4'h0, 0, 0, "R1 reset state");
        step(1'b0, 2'b11, 4'hB, 0, 0, "R5 load 1011");
        step(1'b0, 2'b00, 4'h4, 1, 1, "R2 hold with par_in changing R6");
        step(1'b0, 2'b00, 4'hF, 0, 1, "R2 hold again");
        step(1'b0, 2'b01, 4'h0, 1, 0, "R3 shift right zero in, R6 left pin ignored");
        step(1'b0, 2'b01, 4'hF, 0, 1, "R3 shift right one in, R6 par_in ignored");
        step(1'b0, 2'b01, 4'h0, 0, 1, "R3 shift right one in");
        step(1'b0, 2'b10, 4'hF, 0, 1, "R4 shift left zero in, R6 right pin ignored");
        step(1'b0, 2'b10, 4'h0, 1, 0, "R4 shift left one in");
        step(1'b0, 2'b10, 4'h0, 1, 0, "R4 shift left one in");
        step(1'b0, 2'b10, 4'h0, 0, 1, "R4 shift left zero in");
        step(1'b0, 2'b11, 4'h6, 0, 0, "R5 load 0110");
        step(1'b1, 2'b11, 4'h9, 1, 1, "R1 clear overrides load");
        step(1'b0, 2'b11, 4'h8, 0, 0, "R5 load A end only");
        for (int k = 0; k < W; k++)
            step(1'b0, 2'b01, 4'h0, 1, 0, "R3 walk A-end bit to D end");
        step(1'b0, 2'b11, 4'h1, 0, 0, "R5 load D end only");
        for (int k = 0; k < W; k++)
            step(1'b0, 2'b10, 4'hF, 0, 1, "R4 walk D-end bit out");
        step(1'b0, 2'b11, 4'hF, 0, 0, "R5 load all ones");
        step(1'b1, 2'b01, 4'hF, 1, 1, "R1 clear overrides shift");
        cascade(8'hA5);
        cascade(8'h3C);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule